// File: doc/BRIEF.md
# Write-Guard Status Unit

This block keeps the control state that decides whether a serial nonvolatile memory may be programmed. It holds a write-enable latch, a block-lock code and a busy flag. It formats these into the status byte that a read-status command returns. The serial front end decodes commands into single-cycle pulses for this unit. The unit gives back a combinational permit for the address being written, and a busy indication that lasts until the external program timer reports completion.

Programming needs three things at once: a high level on the write-allow pin, a set write-enable latch, and, for array writes, a target address outside the locked region. The lock code selects a growing upper fraction of the address space. Each byte address of a page write is checked on its own. The program cycle starts at the commit only if at least one of those bytes was allowed. The latch clears itself when any program cycle finishes. Lock bits and latch are plain registers with a reset value.

Top module: `sts_lock_unit`

## Requirements
- R1: After reset the status byte reads 0x00, the lock code is 00 and no write is permitted.
- R2: While idle the status byte carries ready (0) in bit 0, the write-enable latch in bit 1, lock bit 0 in bit 2, lock bit 1 in bit 3 and zeros in bits 7..4.
- R3: While a program cycle runs the status byte reads 0xFF.
- R4: A set-enable pulse sets the latch only when the write-allow pin is high and no program cycle runs.
- R5: A clear-enable pulse clears the latch, and the latch is also cleared on the first clock edge that sees the write-allow pin low.
- R6: A done pulse during a program cycle ends the cycle and clears the latch; the status byte then shows ready with the latch clear.
- R7: The lock code protects these addresses: 00 none, 01 0x180..0x1FF, 10 0x100..0x1FF, 11 0x000..0x1FF; wr_permit_o is 0 for a locked address.
- R8: wr_permit_o is 1 only when the write-allow pin is high, the latch is set, no cycle runs and the address is unlocked, and it follows the pin within the same cycle.
- R9: A status-write commit with pin high and latch set loads the lock code from data bits 3..2, ignores the other bits, and starts a program cycle; otherwise it changes nothing.
- R10: A page commit starts a program cycle when at least one byte address checked since the last commit was permitted, even if others were locked.
- R11: A page commit with no permitted byte starts no cycle and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_allow_i | input | 1 | Write-allow pin level, high allows programming |
| wen_set_i | input | 1 | Set-enable command pulse |
| wen_clr_i | input | 1 | Clear-enable command pulse |
| stat_wr_i | input | 1 | Status-write commit pulse |
| stat_wdata_i | input | 8 | Status-write data byte |
| byte_chk_i | input | 1 | Page byte check pulse for byte_addr_i |
| byte_addr_i | input | ADDR_W | Target byte address |
| page_commit_i | input | 1 | Array write commit pulse |
| prog_done_i | input | 1 | Program timer completion pulse |
| stat_byte_o | output | 8 | Status byte for read-status |
| wr_permit_o | output | 1 | Array write permitted for byte_addr_i |
| bp_o | output | BP_W | Stored lock code |

## Verification
The bench builds the unit with a 9-bit address and a 2-bit lock code, the default values. This makes every lock level reachable, and so every boundary address between a free and a locked region (0x17F/0x180, 0x0FF/0x100, the top and bottom of the space) can be probed directly. With only four levels, the table can revisit each code through the full enable, status-write and done sequence within a few hundred cycles.

// File: rtl/sts_lock_pkg.sv
package sts_lock_pkg;
   localparam int RDY_POS = 0;
   localparam int WEL_POS = 1;
   localparam int BP_POS  = 2;

   // first locked address for level lv: top 2^(aw-(levels-1)+lv) bytes locked
   function automatic longint unsigned lock_base(int aw, int levels, int lv);
      longint unsigned span;
      span = longint'(1) << (aw - (levels - 1) + lv);
      return (longint'(1) << aw) - span;
   endfunction
endpackage

// File: rtl/slu_wel_latch.sv
module slu_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_ok,
   input  logic busy,
   input  logic set_req,
   input  logic clr_req,
   input  logic done,
   output logic wel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wel <= 1'b0;
      else if (!pin_ok)  wel <= 1'b0;
      else if (busy) begin
         if (done)       wel <= 1'b0;
      end
      else if (clr_req)  wel <= 1'b0;
      else if (set_req)  wel <= 1'b1;
   end

   AST_PIN_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_ok |=> !wel); // R5

   AST_SET_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($past(pin_ok) && $past(set_req) && !$past(busy))); // R4

   AST_DONE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !wel); // R6
endmodule

// File: rtl/slu_bp_decode.sv
module slu_bp_decode #(
   parameter int ADDR_W = 9,
   parameter int BP_W   = 2
) (
   input  logic [BP_W-1:0]   code,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   import sts_lock_pkg::*;

   localparam int LEVELS = 1 << BP_W;

   if (ADDR_W < LEVELS - 1) begin : g_bad_width
      $error("ADDR_W too small for the number of lock levels");
   end

   logic [LEVELS-1:0] hit;
   assign hit[0] = 1'b0;

   for (genvar lv = 1; lv < LEVELS; lv++) begin : g_level
      localparam longint unsigned BASE = lock_base(ADDR_W, LEVELS, lv);
      localparam logic [ADDR_W:0] BASE_V = BASE[ADDR_W:0];
      assign hit[lv] = (code == BP_W'(lv)) && ({1'b0, addr} >= BASE_V);
   end

   assign locked = |hit;
endmodule

// File: rtl/slu_busy_ctrl.sv
module slu_busy_ctrl #(
   parameter int              BP_W   = 2,
   parameter logic [BP_W-1:0] BP_RST = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pin_ok,
   input  logic            wel,
   input  logic            chk_req,
   input  logic            chk_ok,
   input  logic            arr_commit,
   input  logic            stat_commit,
   input  logic [BP_W-1:0] stat_bp,
   input  logic            done,
   output logic            busy,
   output logic [BP_W-1:0] bp
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              pend <= 1'b0;
      else if (arr_commit)                     pend <= 1'b0;
      else if (!busy && chk_req && chk_ok)     pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         bp   <= BP_RST;
      end
      else if (busy) begin
         if (done) busy <= 1'b0;
      end
      else if (arr_commit) begin
         if (pend) busy <= 1'b1;
      end
      else if (stat_commit && pin_ok && wel) begin
         busy <= 1'b1;
         bp   <= stat_bp;
      end
   end

   AST_BP_ONLY_BY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_commit |=> $stable(bp)); // R9

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy); // R6

   AST_EMPTY_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && arr_commit && !pend) |=> !busy); // R11
endmodule

// File: rtl/sts_lock_unit.sv
module sts_lock_unit #(
   parameter int              ADDR_W  = 9,
   parameter int              BP_W    = 2,
   parameter int              STAT_W  = 8,
   parameter logic            DC_FILL = 1'b0,
   parameter logic [BP_W-1:0] BP_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_allow_i,
   input  logic              wen_set_i,
   input  logic              wen_clr_i,
   input  logic              stat_wr_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   input  logic              byte_chk_i,
   input  logic [ADDR_W-1:0] byte_addr_i,
   input  logic              page_commit_i,
   input  logic              prog_done_i,
   output logic [STAT_W-1:0] stat_byte_o,
   output logic              wr_permit_o,
   output logic [BP_W-1:0]   bp_o
);
   import sts_lock_pkg::*;

   localparam int PAD_W = STAT_W - BP_POS - BP_W;

   if (PAD_W < 0) begin : g_bad_stat
      $error("status byte too narrow for the lock field");
   end

   logic wel, busy, locked;
   logic [BP_W-1:0] bp;

   slu_wel_latch u_wel (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_ok  (wr_allow_i),
      .busy    (busy),
      .set_req (wen_set_i),
      .clr_req (wen_clr_i),
      .done    (prog_done_i),
      .wel     (wel)
   );

   slu_bp_decode #(.ADDR_W(ADDR_W), .BP_W(BP_W)) u_dec (
      .code   (bp),
      .addr   (byte_addr_i),
      .locked (locked)
   );

   slu_busy_ctrl #(.BP_W(BP_W), .BP_RST(BP_RST)) u_busy (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_ok      (wr_allow_i),
      .wel         (wel),
      .chk_req     (byte_chk_i),
      .chk_ok      (wr_permit_o),
      .arr_commit  (page_commit_i),
      .stat_commit (stat_wr_i),
      .stat_bp     (stat_wdata_i[BP_POS +: BP_W]),
      .done        (prog_done_i),
      .busy        (busy),
      .bp          (bp)
   );

   wire unused_data_bits = ^{stat_wdata_i[STAT_W-1:BP_POS+BP_W], stat_wdata_i[BP_POS-1:0]};

   assign wr_permit_o = wr_allow_i && wel && !busy && !locked;
   assign bp_o        = bp;

   if (PAD_W > 0) begin : g_pad
      assign stat_byte_o = busy ? '1 : {{PAD_W{DC_FILL}}, bp, wel, 1'b0};
   end
   else begin : g_nopad
      assign stat_byte_o = busy ? '1 : {bp, wel, 1'b0};
   end

   AST_BUSY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (stat_byte_o == '1)); // R3

   AST_PERMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit_o |-> (wr_allow_i && stat_byte_o[WEL_POS] && !stat_byte_o[RDY_POS])); // R8
endmodule

// File: tb/sim_sts_lock_unit.sv
module sim_sts_lock_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_allow_i = 1'b1, wen_set_i = 1'b0, wen_clr_i = 1'b0, stat_wr_i = 1'b0;
   logic [7:0] stat_wdata_i = 8'h00;
   logic byte_chk_i = 1'b0, page_commit_i = 1'b0, prog_done_i = 1'b0;
   logic [8:0] byte_addr_i = 9'h000;
   logic [7:0] stat_byte_o;
   logic wr_permit_o;
   logic [1:0] bp_o;

   int n_chk = 0, n_bad = 0;
   bit done_run = 1'b0;

   always #2.5 clk = ~clk;

   sts_lock_unit u0 (.*);

   // {code[1:0], addr[8:0], expected permit}
   localparam logic [11:0] VEC [0:11] = '{
      {2'd0, 9'h000, 1'b1}, {2'd0, 9'h1FF, 1'b1},
      {2'd1, 9'h000, 1'b1}, {2'd1, 9'h17F, 1'b1}, {2'd1, 9'h180, 1'b0}, {2'd1, 9'h1FF, 1'b0},
      {2'd2, 9'h0FF, 1'b1}, {2'd2, 9'h100, 1'b0}, {2'd2, 9'h17F, 1'b0},
      {2'd3, 9'h000, 1'b0}, {2'd3, 9'h0AB, 1'b0}, {2'd3, 9'h1FF, 1'b0}};

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_set();  @(negedge clk) wen_set_i = 1; @(negedge clk) wen_set_i = 0; endtask
   task automatic do_clr();  @(negedge clk) wen_clr_i = 1; @(negedge clk) wen_clr_i = 0; endtask
   task automatic do_done(); @(negedge clk) prog_done_i = 1; @(negedge clk) prog_done_i = 0; endtask
   task automatic do_commit(); @(negedge clk) page_commit_i = 1; @(negedge clk) page_commit_i = 0; endtask
   task automatic do_stat(logic [7:0] d);
      @(negedge clk) begin stat_wr_i = 1; stat_wdata_i = d; end
      @(negedge clk) stat_wr_i = 0;
   endtask
   task automatic do_chk(logic [8:0] a);
      @(negedge clk) begin byte_chk_i = 1; byte_addr_i = a; end
      @(negedge clk) byte_chk_i = 0;
   endtask
   task automatic set_code(logic [1:0] c);
      do_set();
      do_stat({4'hA, c, 2'b11});
      do_done();
      do_set();
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 status", 16'(stat_byte_o), 16'h00);
      check("R1 code", 16'(bp_o), 16'h0);
      check("R1 permit", 16'(wr_permit_o), 16'h0);

      wr_allow_i = 0;
      do_set();
      check("R4 set with pin low", 16'(stat_byte_o), 16'h00);
      wr_allow_i = 1;
      do_set();
      check("R4 set with pin high", 16'(stat_byte_o), 16'h02);
      do_clr();
      check("R5 clear pulse", 16'(stat_byte_o), 16'h00);
      do_set();
      @(negedge clk) wr_allow_i = 0;
      #1 check("R8 permit follows pin", 16'(wr_permit_o), 16'h0);
      @(negedge clk) wr_allow_i = 1;
      check("R5 pin low clears", 16'(stat_byte_o), 16'h00);

      do_stat(8'hFF);
      check("R9 status write without latch", 16'(stat_byte_o), 16'h00);
      do_set();
      do_stat(8'hF4);
      check("R3 busy status", 16'(stat_byte_o), 16'hFF);
      check("R9 code from bits 3..2", 16'(bp_o), 16'h1);
      do_set();
      check("R4 set ignored while busy", 16'(stat_byte_o), 16'hFF);
      do_done();
      check("R6 done", 16'(stat_byte_o), 16'h04);

      for (int i = 0; i < 12; i++) begin
         set_code(VEC[i][11:10]);
         check("R2 idle layout", 16'(stat_byte_o), 16'({4'b0, VEC[i][11:10], 2'b10}));
         @(negedge clk) byte_addr_i = VEC[i][9:1];
         #1 check("R7 lock range", 16'(wr_permit_o), 16'(VEC[i][0]));
      end

      set_code(2'd1);
      do_chk(9'h180);
      do_commit();
      check("R11 all locked commit", 16'(stat_byte_o), 16'h06);
      do_chk(9'h17C);
      do_chk(9'h180);
      do_commit();
      check("R10 partial page starts", 16'(stat_byte_o), 16'hFF);
      do_done();
      check("R6 latch cleared after page", 16'(stat_byte_o), 16'h04);
      @(negedge clk) byte_addr_i = 9'h000;
      #1 check("R8 no latch no permit", 16'(wr_permit_o), 16'h0);

      done_run = 1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_run) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end
endmodule